// File: doc/BRIEF.md
# Serial Register Load Port

This block lets a host write a bank of 8-bit control registers over three wires. The wires are an active-low select, a serial clock and a serial data line. Every select window carries one 16-bit word: an 8-bit register address followed by 8 bits of data, both most significant bit first. The word is committed only when the host releases the select line. A window that carries fewer than sixteen clock pulses is thrown away.

All three wires are asynchronous to the chip. Each one passes through a two-stage synchronizer into a faster system clock domain, and edge detection takes place there. The rest of the chip reads register contents through a parallel read port. Each commit also drives a one-cycle write strobe along with the committed address and data, so that neighbouring logic can react to the update.

Top module: `sreg_load_port`

## Requirements
- R1: While `rst_n` is low, and after it rises, every register entry reads zero and `wr_stb` is low.
- R2: Bits are taken on rising edges of `ser_clk` while `sel_n` is low. Of a 16-bit word sent MSB first, the first 8 bits form the address and the last 8 bits form the data. After a commit, `rd_data` at that address returns the data.
- R3: No register changes while `sel_n` stays low, even after 16 or more bits have arrived. The write takes effect only after `sel_n` rises.
- R4: If fewer than 16 rising edges of `ser_clk` arrive while `sel_n` is low, the frame is discarded. No register changes and no strobe is issued.
- R5: If more than 16 bits arrive in one window, only the last 16 received are used.
- R6: Each commit produces exactly one `wr_stb` pulse, one system clock wide, with `wr_addr` and `wr_data` equal to the committed word.
- R7: Frames sent back to back, with `sel_n` high for one serial clock period between them, are all committed in order.
- R8: A commit changes only the addressed entry. All other entries keep their values.
- R9: Pulses on `ser_clk` while `sel_n` is high have no effect on the registers and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select from the host |
| ser_clk | input | 1 | Serial clock from the host |
| ser_dat | input | 1 | Serial data, sampled on rising `ser_clk` |
| rd_addr | input | 8 | Parallel read address |
| rd_data | output | 8 | Contents of the entry at `rd_addr` |
| wr_stb | output | 1 | One-cycle pulse on each commit |
| wr_addr | output | 8 | Address of the committed word |
| wr_data | output | 8 | Data of the committed word |

## Verification
The assertions rely on the host keeping each serial clock level, and the select high time between frames, much longer than the synchronizer delay. In particular they rely on `sel_n` staying high for at least a couple of system cycles after release, and on the read address being changed only by the bench. The stimulus drives every serial clock half period as 16 system cycles and moves data only while `ser_clk` is low. It also holds select setup, select hold and the inter-frame gap at or above the minimum figures. Random addresses and data are mixed with directed short, long, held-open and idle-clock frames.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   localparam int ADDR_W_DEF = 8;
   localparam int DATA_W_DEF = 8;
   localparam int SYNC_DEF   = 2;

   // synchronized view of the three serial wires
   typedef struct packed {
      logic sel;
      logic sck;
      logic dat;
   } ser_pins_t;

   // reset level of the synchronized wires: select idle high
   localparam ser_pins_t PINS_IDLE = '{sel: 1'b1, sck: 1'b0, dat: 1'b0};
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int              W       = 3,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sreg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg[s] <= RST_VAL;
            end else if (s == 0) begin
               stg[s] <= d_i;
            end else begin
               stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
   import sreg_pkg::*;
#(
   parameter int ADDR_W = ADDR_W_DEF,
   parameter int DATA_W = DATA_W_DEF,
   localparam int WORD_W = ADDR_W + DATA_W,
   localparam int CNT_W  = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ser_pins_t         pins_i,
   output logic              stb_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

   logic              sel_q, sck_q;
   logic              sel_fall, sel_rise, sck_rise;
   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= PINS_IDLE.sel;
         sck_q <= PINS_IDLE.sck;
      end else begin
         sel_q <= pins_i.sel;
         sck_q <= pins_i.sck;
      end
   end

   assign sel_fall = sel_q & ~pins_i.sel;
   assign sel_rise = ~sel_q & pins_i.sel;
   assign sck_rise = ~sck_q & pins_i.sck;

   // shift path: keeps the most recent WORD_W bits, count saturates
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (sel_fall) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (!pins_i.sel && sck_rise) begin
         shreg <= {shreg[WORD_W-2:0], pins_i.dat};
         if (cnt != FULL) cnt <= cnt + 1'b1;
      end
   end

   // commit on select release with a complete word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_o  <= 1'b0;
         addr_o <= '0;
         data_o <= '0;
      end else begin
         stb_o <= sel_rise && (cnt == FULL);
         if (sel_rise && (cnt == FULL)) begin
            addr_o <= shreg[WORD_W-1:DATA_W];
            data_o <= shreg[DATA_W-1:0];
         end
      end
   end

   assign cnt_o = cnt;
endmodule

// File: rtl/sreg_file.sv
module sreg_file #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter bit RD_REG = 1'b0,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we_i) begin
         mem[waddr_i] <= wdata_i;
      end
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_o <= '0;
            else        rdata_o <= mem[raddr_i];
         end
      end else begin : g_rd_comb
         assign rdata_o = mem[raddr_i];
      end
   endgenerate
endmodule

// File: rtl/sreg_load_port.sv
module sreg_load_port
   import sreg_pkg::*;
#(
   parameter int ADDR_W      = ADDR_W_DEF,
   parameter int DATA_W      = DATA_W_DEF,
   parameter int SYNC_STAGES = SYNC_DEF,
   localparam int WORD_W = ADDR_W + DATA_W,
   localparam int CNT_W  = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("sreg_load_port: widths must be positive");
      end
      if (ADDR_W > 12) begin : g_bad_depth
         $error("sreg_load_port: register file too deep");
      end
   endgenerate

   ser_pins_t        pins_raw, pins_s;
   logic [CNT_W-1:0] frm_cnt;

   assign pins_raw = '{sel: sel_n, sck: ser_clk, dat: ser_dat};

   sreg_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PINS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_raw),
      .q_o   (pins_s)
   );

   sreg_frame #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins_i (pins_s),
      .stb_o  (wr_stb),
      .addr_o (wr_addr),
      .data_o (wr_data),
      .cnt_o  (frm_cnt)
   );

   sreg_file #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .RD_REG (1'b0)
   ) u_file (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (wr_stb),
      .waddr_i (wr_addr),
      .wdata_i (wr_data),
      .raddr_i (rd_addr),
      .rdata_o (rd_data)
   );
endmodule

// File: rtl/sreg_load_chk.sv
module sreg_load_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 5,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic              sel_s,
   input logic [CNT_W-1:0]  cnt,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data
);
   // R1
   always_comb begin
      if (!rst_n) reset_quiet_chk: assert (!wr_stb);
   end

   // R6
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R3
   commit_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> sel_s);

   // R5
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(WORD_W));

   // R4
   hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(rd_addr) && !$past(wr_stb)) |-> $stable(rd_data));
endmodule

bind sreg_load_port sreg_load_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .WORD_W (WORD_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_stb  (wr_stb),
   .sel_s   (pins_s.sel),
   .cnt     (frm_cnt),
   .rd_addr (rd_addr),
   .rd_data (rd_data)
);

// File: tb/sreg_load_port_tb.sv
module sreg_load_port_tb;
   localparam int HALF = 16; // system cycles per serial clock half period

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_n = 1'b1;
   logic       ser_clk = 1'b0;
   logic       ser_dat = 1'b0;
   logic [7:0] rd_addr = 8'h00;
   logic [7:0] rd_data;
   logic       wr_stb;
   logic [7:0] wr_addr, wr_data;

   int n_checks = 0;
   int n_fail   = 0;
   int stb_cnt  = 0;
   int stb_wide = 0;
   logic [7:0] last_a = 8'h00, last_d = 8'h00;
   logic prev_stb = 1'b0;
   bit   done = 1'b0;
   logic [7:0] model [256];

   always #4 clk = ~clk;

   sreg_load_port u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_n   (sel_n),
      .ser_clk (ser_clk),
      .ser_dat (ser_dat),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   always @(negedge clk) begin
      if (wr_stb) begin
         stb_cnt++;
         last_a = wr_addr;
         last_d = wr_data;
         if (prev_stb) stb_wide++;
      end
      prev_stb = wr_stb;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] make_word(input logic [7:0] a, input logic [7:0] d);
      return {a, d};
   endfunction

   // shift n bits of w, MSB first, inside one open window
   task automatic shift_bits(input logic [31:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = w[i];
         wait_clk(HALF);
         ser_clk = 1'b1;
         wait_clk(HALF);
         ser_clk = 1'b0;
      end
   endtask

   task automatic open_win();
      sel_n = 1'b0;
      wait_clk(8);
   endtask

   task automatic close_win();
      wait_clk(8);
      sel_n = 1'b1;
      wait_clk(2 * HALF); // one serial clock period gap
   endtask

   task automatic send(input logic [31:0] w, input int n);
      open_win();
      shift_bits(w, n);
      close_win();
   endtask

   function automatic logic [7:0] peek_read(input logic [7:0] a);
      return model[a];
   endfunction

   task automatic read_chk(input logic [7:0] a, input string req);
      rd_addr = a;
      #1;
      chk(rd_data == peek_read(a), req, rd_data, peek_read(a));
   endtask

   task automatic sweep(input string req);
      int bad = 0;
      for (int a = 0; a < 256; a++) begin
         rd_addr = 8'(a);
         #1;
         if (rd_data !== model[a]) begin
            bad++;
            $display("FAIL %s entry 0x%0h actual=0x%0h expected=0x%0h", req, a, rd_data, model[a]);
         end
      end
      n_checks++;
      if (bad != 0) n_fail++;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int s0;
      logic [7:0] a, d, a2, d2;
      logic [7:0] aa [4];
      logic [7:0] dd [4];
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) model[i] = 8'h00;

      // R1: reset state
      wait_clk(3);
      chk(wr_stb == 1'b0, "R1 strobe in reset", wr_stb, 0);
      sweep("R1 reset contents");
      rst_n = 1'b1;
      wait_clk(4);
      chk(wr_stb == 1'b0, "R1 strobe after reset", wr_stb, 0);

      // R2, R6: directed word
      s0 = stb_cnt;
      send(make_word(8'hA5, 8'h3C), 16);
      model[8'hA5] = 8'h3C;
      read_chk(8'hA5, "R2 directed write");
      chk(stb_cnt == s0 + 1, "R6 one strobe", stb_cnt - s0, 1);
      chk({last_a, last_d} == 16'hA53C, "R6 strobe addr/data", {last_a, last_d}, 16'hA53C);

      // R2, R8: boundary addresses and random words
      send(make_word(8'h00, 8'hFF), 16); model[8'h00] = 8'hFF;
      send(make_word(8'hFF, 8'h01), 16); model[8'hFF] = 8'h01;
      read_chk(8'h00, "R2 address 0");
      read_chk(8'hFF, "R2 address 255");
      for (int k = 0; k < 24; k++) begin
         a = 8'($urandom);
         d = 8'($urandom);
         s0 = stb_cnt;
         send(make_word(a, d), 16);
         model[a] = d;
         read_chk(a, "R2 random write");
         chk(stb_cnt == s0 + 1 && last_a == a && last_d == d, "R6 random strobe",
             {last_a, last_d}, {a, d});
      end
      sweep("R8 untouched entries");

      // R3: full word but window held open
      a = 8'h5A; d = 8'hC3;
      s0 = stb_cnt;
      open_win();
      shift_bits(make_word(a, d), 16);
      wait_clk(40);
      read_chk(a, "R3 no write while select low");
      chk(stb_cnt == s0, "R3 no strobe while select low", stb_cnt - s0, 0);
      close_win();
      model[a] = d;
      read_chk(a, "R3 write after release");

      // R4: short frame of 15 bits
      s0 = stb_cnt;
      send(32'h0000_7E55, 15);
      chk(stb_cnt == s0, "R4 short frame strobe", stb_cnt - s0, 0);
      sweep("R4 short frame discarded");

      // R5: 20 bits with leading junk
      a = 8'h77; d = 8'h99;
      send({12'h000, 4'hB, a, d}, 20);
      model[a] = d;
      read_chk(a, "R5 last 16 bits used");
      chk(last_a == a && last_d == d, "R5 strobe word", {last_a, last_d}, {a, d});

      // R9: serial clock pulses with select high
      s0 = stb_cnt;
      shift_bits(32'h0000_ABCD, 16);
      wait_clk(20);
      chk(stb_cnt == s0, "R9 idle clocks no strobe", stb_cnt - s0, 0);
      sweep("R9 idle clocks no change");

      // R7: back-to-back frames with minimum gap
      s0 = stb_cnt;
      for (int k = 0; k < 4; k++) begin
         aa[k] = 8'(8'h10 + 8'(k * 17));
         dd[k] = 8'($urandom);
      end
      for (int k = 0; k < 4; k++) send(make_word(aa[k], dd[k]), 16);
      for (int k = 0; k < 4; k++) model[aa[k]] = dd[k];
      chk(stb_cnt == s0 + 4, "R7 four commits", stb_cnt - s0, 4);
      for (int k = 0; k < 4; k++) read_chk(aa[k], "R7 back-to-back contents");

      // R7: same address twice, later wins
      a2 = 8'h42; d = 8'h11; d2 = 8'h22;
      send(make_word(a2, d), 16);
      send(make_word(a2, d2), 16);
      model[a2] = d2;
      read_chk(a2, "R7 order kept");

      chk(stb_wide == 0, "R6 strobe width", stb_wide, 0);
      sweep("R8 final contents");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule